// File: doc/BRIEF.md
# Dead-Time Sub-Counter with Setting Error Detection

This block is the auxiliary up/down counter of a complementary triangle-wave PWM timer. It runs back and forth between a floor given by the first dead-time value (`dt0_i`) and a ceiling equal to the period minus the second dead-time value (`period_i - dt1_i`). It reverses direction when its count equals one of these two turn points.

If the configuration is wrong, the counter can miss a turn point. It then runs to a hard limit: zero when counting down, or the largest usable count when counting up. At that limit it reloads `dt0_i`, resumes counting up, and raises a one-cycle overflow interrupt. The same event sets a sticky flag.

A correct setting never reaches either hard limit. The interrupt therefore acts as a detector for bad configuration. A separate combinational output reports whether the present setting meets both static range rules.

Top module: `dt_subcnt`

## Requirements
- R1: `setting_ok_o` is low whenever `3*max(dt0_i,dt1_i) + min(dt0_i,dt1_i) >= period_i`. The sum is formed wide enough that it cannot wrap.
- R2: `setting_ok_o` is high only when `period_i` is above 0x0002 and at most 0xFFFE, and R1's sum is below `period_i`.
- R3: After reset, `cnt_o`=0, `dir_up_o`=1 (1 means counting up), and `ovf_irq_o` and `ovf_flag_o` are both 0. While `en_i` is low the counter and direction hold. On the first clock with `en_i` high after reset or after `en_i` was low, `cnt_o` loads `dt0_i` and `dir_up_o` becomes 1.
- R4: While counting up, the count increments by one. When the count equals `period_i - dt1_i` (16-bit difference), the direction flips to down and the count decrements by one in that same clock. This match takes priority over R7.
- R5: While counting down, the count decrements by one. When the count equals `dt0_i`, the direction flips to up and the count increments by one in that same clock. This match takes priority over R6.
- R6: While counting down, if the count is 0x0000 without a `dt0_i` match, the counter loads `dt0_i`, sets the direction to up, and raises the overflow event.
- R7: While counting up, if the count is 0xFFFE or above without a turn-point match, the counter loads `dt0_i`, sets the direction to up, and raises the overflow event.
- R8: `ovf_irq_o` is high for exactly the clock after each overflow event, which is the same edge at which the reload is registered. `ovf_flag_o` sets with it and stays set until `ovf_clr_i` is sampled high with no new event, or until reset. If an event and a clear arrive together, the set wins.
- R9: With a setting for which `setting_ok_o` is high, and with the counter started from `dt0_i`, `ovf_irq_o` never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable; a rising level restarts from dt0_i |
| period_i | input | 16 | Period value |
| dt0_i | input | 16 | Dead-time value forming the lower turn point |
| dt1_i | input | 16 | Dead-time value subtracted from the period for the upper turn point |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| cnt_o | output | 16 | Sub-counter value |
| dir_up_o | output | 1 | 1 = counting up, 0 = counting down |
| ovf_irq_o | output | 1 | One-cycle overflow interrupt |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| setting_ok_o | output | 1 | Current setting satisfies both range rules |

## Verification
The checker enforces several rules on every clock:
- the enable-edge load;
- the single-step increment between turn points;
- the forced reload at both hard limits;
- that every interrupt coincides with a `dt0_i` reload and a set flag;
- that the flag is sticky.

Some behaviour can only be shown by the bench scenarios. These are the full range-rule truth table across small and near-limit periods, the absence of any interrupt across a sweep of valid settings (R9), a down-count miss provoked by raising `dt0_i` mid-descent, and the interplay between clear and set on the flag.

// File: rtl/dt_subcnt_pkg.sv
package dt_subcnt_pkg;
  localparam int unsigned CNT_W = 16;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_LOW  = 2'd1,
    EV_HIGH = 2'd2
  } ovf_src_e;
endpackage

// File: rtl/dt_range_chk.sv
module dt_range_chk #(
  parameter int unsigned W = dt_subcnt_pkg::CNT_W
) (
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] dt0_i,
  input  logic [W-1:0] dt1_i,
  output logic         ok_o
);
  localparam int unsigned SW = W + 2;
  localparam logic [W-1:0] PER_MIN = W'(2);
  localparam logic [W-1:0] PER_MAX = {{(W-1){1'b1}}, 1'b0};

  logic [SW-1:0] hi_x, lo_x, sum_x;
  logic          ratio_ok, span_ok;

  always_comb begin
    hi_x     = (dt0_i > dt1_i) ? SW'(dt0_i) : SW'(dt1_i);
    lo_x     = (dt0_i > dt1_i) ? SW'(dt1_i) : SW'(dt0_i);
    sum_x    = (hi_x << 1) + hi_x + lo_x;
    ratio_ok = sum_x < SW'(period_i);
    span_ok  = (period_i > PER_MIN) && (period_i <= PER_MAX);
    ok_o     = ratio_ok && span_ok;
  end
endmodule

// File: rtl/dt_cnt_core.sv
module dt_cnt_core
  import dt_subcnt_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] dt0_i,
  input  logic [W-1:0] dt1_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_up_o,
  output ovf_src_e     ovf_src_o
);
  localparam logic [W-1:0] CNT_LIM = {{(W-1){1'b1}}, 1'b0};

  logic [W-1:0] cnt_q, cnt_d, top_w;
  logic         up_q, up_d, en_q;
  ovf_src_e     src;

  assign top_w = period_i - dt1_i;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    src   = EV_NONE;
    if (en_i) begin
      if (!en_q) begin
        cnt_d = dt0_i;
        up_d  = 1'b1;
      end else if (up_q) begin
        if (cnt_q == top_w) begin
          up_d  = 1'b0;
          cnt_d = cnt_q - W'(1);
        end else if (cnt_q >= CNT_LIM) begin
          cnt_d = dt0_i;
          src   = EV_HIGH;
        end else begin
          cnt_d = cnt_q + W'(1);
        end
      end else begin
        if (cnt_q == dt0_i) begin
          up_d  = 1'b1;
          cnt_d = cnt_q + W'(1);
        end else if (cnt_q == '0) begin
          cnt_d = dt0_i;
          up_d  = 1'b1;
          src   = EV_LOW;
        end else begin
          cnt_d = cnt_q - W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      en_q  <= en_i;
    end
  end

  assign cnt_o     = cnt_q;
  assign dir_up_o  = up_q;
  assign ovf_src_o = src;
endmodule

// File: rtl/dt_ovf_latch.sv
module dt_ovf_latch
  import dt_subcnt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ovf_src_e src_i,
  input  logic     clr_i,
  output logic     irq_o,
  output logic     flag_o
);
  logic hit, irq_q, flag_q;

  assign hit = (src_i != EV_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      irq_q <= hit;
      if (hit)        flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign irq_o  = irq_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/dt_subcnt.sv
module dt_subcnt
  import dt_subcnt_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] dt0_i,
  input  logic [W-1:0] dt1_i,
  input  logic         ovf_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_up_o,
  output logic         ovf_irq_o,
  output logic         ovf_flag_o,
  output logic         setting_ok_o
);
  ovf_src_e src;

  dt_range_chk #(.W(W)) u_range (
    .period_i(period_i), .dt0_i(dt0_i), .dt1_i(dt1_i), .ok_o(setting_ok_o)
  );

  dt_cnt_core #(.W(W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .period_i(period_i), .dt0_i(dt0_i), .dt1_i(dt1_i),
    .cnt_o(cnt_o), .dir_up_o(dir_up_o), .ovf_src_o(src)
  );

  dt_ovf_latch u_ovf (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src), .clr_i(ovf_clr_i),
    .irq_o(ovf_irq_o), .flag_o(ovf_flag_o)
  );
endmodule

// File: rtl/dt_subcnt_chk.sv
module dt_subcnt_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic [W-1:0] period_i,
  input logic [W-1:0] dt0_i,
  input logic [W-1:0] dt1_i,
  input logic         ovf_clr_i,
  input logic [W-1:0] cnt_o,
  input logic         dir_up_o,
  input logic         ovf_irq_o,
  input logic         ovf_flag_o
);
  localparam logic [W-1:0] LIM = {{(W-1){1'b1}}, 1'b0};

  logic         en_d;
  logic [W-1:0] top;

  assign top = period_i - dt1_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_d <= 1'b0;
    else         en_d <= en_i;
  end

  // R3
  enable_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !en_d) |=> (cnt_o == $past(dt0_i) && dir_up_o));

  // R4
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_d && dir_up_o && cnt_o < LIM && cnt_o != top)
      |=> (cnt_o == W'($past(cnt_o) + W'(1)) && dir_up_o));

  // R6
  low_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_d && !dir_up_o && cnt_o == '0 && dt0_i != '0)
      |=> (ovf_irq_o && dir_up_o));

  // R7
  high_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_d && dir_up_o && cnt_o >= LIM && cnt_o != top)
      |=> (ovf_irq_o && cnt_o == $past(dt0_i)));

  // R8
  irq_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_o |-> (ovf_flag_o && dir_up_o && cnt_o == $past(dt0_i)));

  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o);
endmodule

bind dt_subcnt dt_subcnt_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .period_i(period_i),
  .dt0_i(dt0_i), .dt1_i(dt1_i), .ovf_clr_i(ovf_clr_i), .cnt_o(cnt_o),
  .dir_up_o(dir_up_o), .ovf_irq_o(ovf_irq_o), .ovf_flag_o(ovf_flag_o)
);

// File: tb/dt_subcnt_tb_top.sv
module dt_subcnt_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, clr = 1'b0;
  logic [15:0] per = '0, d0 = '0, d1 = '0;
  logic [15:0] cnt;
  logic        dir, irq, flag, ok;

  int n_chk = 0, n_fail = 0, cyc = 0, irq_seen = 0;
  logic [15:0] e_cnt;
  logic        e_dir, e_irq, e_flag, e_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  dt_subcnt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .period_i(per), .dt0_i(d0),
    .dt1_i(d1), .ovf_clr_i(clr), .cnt_o(cnt), .dir_up_o(dir),
    .ovf_irq_o(irq), .ovf_flag_o(flag), .setting_ok_o(ok)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
    end
  endtask

  // one clock: inputs already applied; update model, compare after edge
  task automatic step();
    string rq;
    logic [15:0] top;
    logic ev;
    top = per - d1;
    ev = 1'b0;
    rq = "R3";
    @(posedge clk);
    cyc++;
    if (en) begin
      if (!e_en) begin
        e_cnt = d0; e_dir = 1'b1;
      end else if (e_dir) begin
        if (e_cnt == top) begin
          e_dir = 1'b0; e_cnt = e_cnt - 16'd1; rq = "R4";
        end else if (e_cnt >= 16'hFFFE) begin
          e_cnt = d0; ev = 1'b1; rq = "R7";
        end else begin
          e_cnt = e_cnt + 16'd1; rq = "R4";
        end
      end else begin
        if (e_cnt == d0) begin
          e_dir = 1'b1; e_cnt = e_cnt + 16'd1; rq = "R5";
        end else if (e_cnt == 16'd0) begin
          e_cnt = d0; e_dir = 1'b1; ev = 1'b1; rq = "R6";
        end else begin
          e_cnt = e_cnt - 16'd1; rq = "R5";
        end
      end
    end
    e_en = en;
    e_irq = ev;
    if (ev) e_flag = 1'b1;
    else if (clr) e_flag = 1'b0;
    #1;
    chk(rq, 32'(cnt), 32'(e_cnt));
    chk(rq, 32'(dir), 32'(e_dir));
    chk("R8", 32'(irq), 32'(e_irq));
    chk("R8", 32'(flag), 32'(e_flag));
    if (irq) irq_seen++;
    @(negedge clk);
  endtask

  function automatic logic exp_ok(input logic [15:0] p, input logic [15:0] a, input logic [15:0] b);
    logic [17:0] mx, mn;
    mx = (a > b) ? 18'(a) : 18'(b);
    mn = (a > b) ? 18'(b) : 18'(a);
    return (3 * mx + mn < 18'(p)) && (p > 16'd2) && (p <= 16'hFFFE);
  endfunction

  initial begin : watchdog
    repeat (WDOG_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    e_cnt = '0; e_dir = 1'b1; e_irq = 1'b0; e_flag = 1'b0; e_en = 1'b0;
    #(CLK_PERIOD * 2 + 2);
    // reset state R3
    chk("R3", 32'(cnt), 0); chk("R3", 32'(dir), 1);
    chk("R3", 32'(irq), 0); chk("R3", 32'(flag), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2 range-rule sweep
    for (int p = 0; p < 40; p++) begin
      for (int a = 0; a < 12; a++) begin
        for (int b = 0; b < 12; b++) begin
          per = 16'(p); d0 = 16'(a); d1 = 16'(b);
          #1;
          chk((p > 2) ? "R1" : "R2", 32'(ok), 32'(exp_ok(per, d0, d1)));
        end
      end
    end
    for (int p = 16'hFFFB; p <= 16'hFFFF; p++) begin
      for (int a = 0; a < 3; a++) begin
        per = 16'(p); d0 = 16'(a * 16'h4000); d1 = 16'(a);
        #1;
        chk("R2", 32'(ok), 32'(exp_ok(per, d0, d1)));
      end
    end
    d0 = 16'hFFFF; d1 = 16'hFFFF; per = 16'hFFFE; #1;
    chk("R1", 32'(ok), 0);

    // R3 hold while disabled
    per = 16'd20; d0 = 16'd3; d1 = 16'd2;
    repeat (3) step();

    // R9 sweep over valid settings, restart each time
    for (int p = 3; p < 24; p++) begin
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          if (exp_ok(16'(p), 16'(a), 16'(b))) begin
            en = 1'b0; per = 16'(p); d0 = 16'(a); d1 = 16'(b);
            step();
            en = 1'b1;
            irq_seen = 0;
            repeat (2 * p + 6) step();
            chk("R9", 32'(irq_seen), 0);
          end
        end
      end
    end

    // R6: raise dt0 during descent
    en = 1'b0; per = 16'd20; d0 = 16'd2; d1 = 16'd2; step();
    en = 1'b1;
    while (!(e_dir == 1'b0 && e_cnt == 16'd10)) step();
    d0 = 16'd15;
    irq_seen = 0;
    repeat (30) step();
    chk("R6", 32'(irq_seen), 1);
    chk("R8", 32'(flag), 1);
    // R8 clear
    clr = 1'b1; step(); clr = 1'b0; step();
    chk("R8", 32'(flag), 0);

    // R7: start above the upper turn point
    en = 1'b0; d0 = 16'hFFF0; step();
    en = 1'b1;
    irq_seen = 0;
    repeat (40) step();
    chk("R7", 32'(irq_seen), 2);
    chk("R1", 32'(ok), 0);

    // R7 / R8: start at the limit, clear colliding with events
    en = 1'b0; d0 = 16'hFFFE; step();
    en = 1'b1; clr = 1'b1;
    repeat (5) step();
    clr = 1'b0;
    chk("R8", 32'(flag), 1);

    // R3: disable mid-run holds count
    en = 1'b0; d0 = 16'd4; step(); step();
    en = 1'b1; repeat (5) step();
    en = 1'b0; repeat (4) step();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule